// File: doc/BRIEF.md
# Pause Frame Transmit Sequencer

This block sends a single full-duplex flow-control pause frame when software asks for one. It first tells the MAC data transmitter to stop gracefully, so that no new data frame begins. It then waits for the frame already in flight to finish and raises a one-cycle stop-complete interrupt. After that it streams the pause frame one byte at a time into the MAC transmitter, which adds the FCS. When the last byte has been accepted, the block clears the software request bit and the stop request by itself.

The frame is built from fixed constants and two inputs. The inputs are the station address and a 16-bit pause time. Both are captured when the request is accepted. The header and pause time are followed by zero bytes up to the minimum frame length. The byte stream has start and end markers and follows a valid/ready handshake. Requests made while the link is in half-duplex are ignored.

Top module: `pause_tx_seq`

## Requirements
- R1: While `full_duplex` is 0 in the idle state, a set `sw_pause_req` is ignored: `gstop_req`, `tx_valid` and `req_clear` all stay 0.
- R2: With `full_duplex` at 1, a set `sw_pause_req` seen by an idle sequencer drives `gstop_req` to 1 one clock later.
- R3: While `data_tx_idle` stays 0 after a request, the block holds `gstop_req` at 1 and raises neither `gstop_done_irq` nor `tx_valid`.
- R4: The first clock edge that sees `data_tx_idle` at 1 during the stop wait raises `gstop_done_irq` for exactly one cycle. The first frame byte is offered in the cycle after that pulse, never earlier and never in the same cycle.
- R5: The frame is `MIN_BYTES` (default 60) bytes long. It carries, in this order and each field most significant byte first: 01 80 C2 00 00 01, the six bytes of `station_addr` (bits 47:40 first), 88 08, 00 01, then `pause_dur` bits 15:8 and 7:0. All remaining bytes are 00.
- R6: `tx_sof` is 1 only on byte 0 and `tx_eof` is 1 only on the last byte. Both are 0 whenever `tx_valid` is 0.
- R7: The cycle after the last byte is accepted, `req_clear` is 1 for one cycle while `gstop_req` is still 1. In the following cycle `gstop_req` is 0.
- R8: A byte advances only on a clock edge where both `tx_valid` and `tx_ready` are 1. While `tx_ready` is 0, `tx_data`, `tx_sof` and `tx_eof` hold their values.
- R9: `station_addr` and `pause_dur` are captured when a request is accepted. Changing them during the frame does not alter the bytes sent.
- R10: The request and `full_duplex` are sampled only in the idle state. Dropping `full_duplex` after acceptance does not abort the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_pause_req | input | 1 | Software pause request bit |
| full_duplex | input | 1 | Full-duplex mode bit |
| station_addr | input | 48 | Station physical address, used as the frame source |
| pause_dur | input | 16 | Pause time placed in the frame |
| data_tx_idle | input | 1 | MAC data transmitter has no frame in progress |
| tx_ready | input | 1 | Downstream accepts a byte this cycle |
| gstop_req | output | 1 | Graceful-stop request to the data transmitter |
| gstop_done_irq | output | 1 | One-cycle graceful-stop-complete interrupt |
| req_clear | output | 1 | One-cycle strobe that clears the software request bit |
| tx_valid | output | 1 | A frame byte is offered |
| tx_data | output | 8 | Frame byte |
| tx_sof | output | 1 | First byte of the frame |
| tx_eof | output | 1 | Last byte of the frame |

## Verification
The assertions watch, on every cycle, the relations that hold between ports:
- bytes are offered only under a stop request;
- the interrupt is a single-cycle pulse that never coincides with a byte;
- the markers are exclusive and appear only with a valid byte;
- a stalled byte stays stable;
- an accepted end marker is followed by the clear strobe, and the stop request then falls.

Only the bench scenarios can show the rest. These are the exact byte contents and their order, the exact cycle of the interrupt after the transmitter goes idle, and that a half-duplex request is ignored. They also show that changes to the address, the pause time and the mode bit have no effect mid-frame. The sweep covers pause times, stall patterns and busy lengths.

// File: rtl/pause_tx_pkg.sv
`timescale 1ns/1ps
package pause_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_STOP_WAIT = 2'd1,
    ST_SEND      = 2'd2,
    ST_DONE      = 2'd3
  } pseq_state_e;

  localparam int          MAC_W      = 48;
  localparam int          QUANTA_W   = 16;
  localparam int          FIELD16_W  = 16;
  localparam logic [47:0] CTRL_DEST  = 48'h0180_C200_0001;
  localparam logic [15:0] CTRL_ETYPE = 16'h8808;
  localparam logic [15:0] CTRL_OPC   = 16'h0001;
  localparam int          HDR_BITS   = 2 * MAC_W + 2 * FIELD16_W + QUANTA_W;
  localparam int          HDR_BYTES  = HDR_BITS / 8;
endpackage

// File: rtl/pause_rst_sync.sv
`timescale 1ns/1ps
module pause_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pause_seq_fsm.sv
`timescale 1ns/1ps
module pause_seq_fsm
  import pause_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_req,
  input  logic fdx,
  input  logic dtx_idle,
  input  logic ready,
  input  logic last_byte,
  output logic load,
  output logic adv,
  output logic byte_valid,
  output logic stop_req,
  output logic stop_irq,
  output logic clr_strobe
);
  pseq_state_e state_q, state_d;
  logic        irq_q, irq_d;

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (sw_req && fdx) state_d = ST_STOP_WAIT;
      ST_STOP_WAIT: if (dtx_idle)      state_d = ST_SEND;
      ST_SEND:      if (adv && last_byte) state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  assign irq_d = (state_q == ST_STOP_WAIT) && dtx_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  // the first SEND cycle carries the interrupt pulse; bytes follow it
  assign byte_valid = (state_q == ST_SEND) && !irq_q;
  assign adv        = byte_valid && ready;
  assign load       = (state_q == ST_IDLE) && sw_req && fdx;
  assign stop_req   = (state_q != ST_IDLE);
  assign stop_irq   = irq_q;
  assign clr_strobe = (state_q == ST_DONE);
endmodule

// File: rtl/pause_byte_ctr.sv
`timescale 1ns/1ps
module pause_byte_ctr #(
  parameter int MIN_BYTES = 60,
  localparam int IDX_W = $clog2(MIN_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign idx_en = clr || adv;

  always_comb begin
    idx_d = idx_q;
    if (clr)      idx_d = '0;
    else if (adv) idx_d = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx  = idx_q;
  assign last = (idx_q == IDX_W'(MIN_BYTES - 1));
endmodule

// File: rtl/pause_frame_mux.sv
`timescale 1ns/1ps
module pause_frame_mux
  import pause_tx_pkg::*;
#(
  parameter int MIN_BYTES = 60,
  localparam int IDX_W = $clog2(MIN_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAC_W-1:0]    src_in,
  input  logic [QUANTA_W-1:0] dur_in,
  input  logic [IDX_W-1:0]    idx,
  output logic [7:0]          byte_o
);
  logic [MAC_W-1:0]    src_q;
  logic [QUANTA_W-1:0] dur_q;
  logic [HDR_BITS-1:0] hdr_vec;
  logic [7:0]          hdr_b [HDR_BYTES];

  // capture frame fields at request acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dur_q <= '0;
    end else if (load) begin
      src_q <= src_in;
      dur_q <= dur_in;
    end
  end

  assign hdr_vec = {CTRL_DEST, src_q, CTRL_ETYPE, CTRL_OPC, dur_q};

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
    assign hdr_b[g] = hdr_vec[(HDR_BYTES-1-g)*8 +: 8];
  end

  // bytes past the header are zero padding
  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < HDR_BYTES; i++) begin
      if (idx == IDX_W'(i)) byte_o = hdr_b[i];
    end
  end
endmodule

// File: rtl/pause_tx_seq.sv
`timescale 1ns/1ps
module pause_tx_seq
  import pause_tx_pkg::*;
#(
  parameter int MIN_BYTES = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_pause_req,
  input  logic        full_duplex,
  input  logic [47:0] station_addr,
  input  logic [15:0] pause_dur,
  input  logic        data_tx_idle,
  input  logic        tx_ready,
  output logic        gstop_req,
  output logic        gstop_done_irq,
  output logic        req_clear,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_sof,
  output logic        tx_eof
);
  localparam int IDX_W = $clog2(MIN_BYTES);

  logic             rst_n_i;
  logic             load, adv, last_byte;
  logic [IDX_W-1:0] idx;

  pause_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  pause_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .sw_req     (sw_pause_req),
    .fdx        (full_duplex),
    .dtx_idle   (data_tx_idle),
    .ready      (tx_ready),
    .last_byte  (last_byte),
    .load       (load),
    .adv        (adv),
    .byte_valid (tx_valid),
    .stop_req   (gstop_req),
    .stop_irq   (gstop_done_irq),
    .clr_strobe (req_clear)
  );

  pause_byte_ctr #(.MIN_BYTES(MIN_BYTES)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n_i),
    .clr   (load),
    .adv   (adv),
    .idx   (idx),
    .last  (last_byte)
  );

  pause_frame_mux #(.MIN_BYTES(MIN_BYTES)) u_mux (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .load   (load),
    .src_in (station_addr),
    .dur_in (pause_dur),
    .idx    (idx),
    .byte_o (tx_data)
  );

  assign tx_sof = tx_valid && (idx == '0);
  assign tx_eof = tx_valid && last_byte;
endmodule

// File: rtl/pause_tx_seq_chk.sv
`timescale 1ns/1ps
module pause_tx_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       full_duplex,
  input logic       tx_ready,
  input logic       gstop_req,
  input logic       gstop_done_irq,
  input logic       req_clear,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_sof,
  input logic       tx_eof
);
  a_r1_half_duplex_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!gstop_req && !full_duplex) |=> !gstop_req);

  a_r3_bytes_under_stop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> gstop_req);

  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    gstop_done_irq |=> !gstop_done_irq);

  a_r4_irq_before_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    gstop_done_irq |-> (!tx_valid && gstop_req));

  a_r6_markers_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sof || tx_eof) |-> tx_valid);

  a_r6_markers_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_sof, tx_eof}));

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)));

  a_r7_eof_then_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_eof && tx_ready) |=> (req_clear && gstop_req));

  a_r7_clear_drops_stop: assert property (@(posedge clk) disable iff (!rst_n)
    req_clear |=> (!gstop_req && !req_clear));
endmodule

bind pause_tx_seq pause_tx_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .full_duplex    (full_duplex),
  .tx_ready       (tx_ready),
  .gstop_req      (gstop_req),
  .gstop_done_irq (gstop_done_irq),
  .req_clear      (req_clear),
  .tx_valid       (tx_valid),
  .tx_data        (tx_data),
  .tx_sof         (tx_sof),
  .tx_eof         (tx_eof)
);

// File: tb/tb_pause_tx_seq.sv
`timescale 1ns/1ps
module tb_pause_tx_seq;
  localparam int MINB = 60;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_pause_req, full_duplex, data_tx_idle, tx_ready;
  logic [47:0] station_addr;
  logic [15:0] pause_dur;
  logic        gstop_req, gstop_done_irq, req_clear, tx_valid, tx_sof, tx_eof;
  logic [7:0]  tx_data;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  ended  = 0;

  always #2.5 clk = ~clk;

  pause_tx_seq #(.MIN_BYTES(MINB)) dut (
    .clk(clk), .rst_n(rst_n), .sw_pause_req(sw_pause_req), .full_duplex(full_duplex),
    .station_addr(station_addr), .pause_dur(pause_dur), .data_tx_idle(data_tx_idle),
    .tx_ready(tx_ready), .gstop_req(gstop_req), .gstop_done_irq(gstop_done_irq),
    .req_clear(req_clear), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i, input logic [47:0] a,
                                          input logic [15:0] d);
    logic [143:0] h;
    h = {48'h0180C2000001, a, 16'h8808, 16'h0001, d};
    if (i < 18) return h[(17 - i) * 8 +: 8];
    return 8'h00;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // one complete request: busy = cycles the data transmitter stays busy
  task automatic run_frame(input logic [47:0] a, input logic [15:0] d,
                           input int mode, input int busy);
    int idx = 0;
    int irq_n = 0;
    int exp_irq;
    bit done = 0;
    bit pv = 0, pr = 0;
    logic [7:0] pd = 8'h00;
    exp_irq = ((busy < 1) ? 1 : busy) + 1;
    @(negedge clk);
    station_addr = a; pause_dur = d; full_duplex = 1'b1;
    data_tx_idle = (busy == 0); sw_pause_req = 1'b1;
    for (int c = 1; c < 1000 && !done; c++) begin
      @(negedge clk);
      if (c == busy) data_tx_idle = 1'b1;
      tx_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (c % 2 == 0) : (c % 3 != 0);
      #1;
      if (c == 1) chk(gstop_req == 1'b1, "R2", "stop request after accept", gstop_req, 1);
      if (c < exp_irq) begin
        chk(!gstop_done_irq && !tx_valid, "R3", "no irq/bytes while busy",
            {gstop_done_irq, tx_valid}, 0);
        if (c >= 1) chk(gstop_req, "R3", "stop held while busy", gstop_req, 1);
      end
      if (c == exp_irq) chk(gstop_done_irq, "R4", "irq cycle", gstop_done_irq, 1);
      if (gstop_done_irq) irq_n++;
      if (tx_valid) begin
        chk(irq_n == 1 && !gstop_done_irq, "R4", "byte after single irq", irq_n, 1);
        if (pv && !pr) chk(tx_data == pd, "R8", "stalled byte held", tx_data, pd);
        chk(tx_data == exp_byte(idx, a, d), "R5", $sformatf("byte %0d", idx),
            tx_data, exp_byte(idx, a, d));
        chk(tx_sof == (idx == 0) && tx_eof == (idx == MINB - 1), "R6",
            $sformatf("markers at byte %0d", idx), {tx_sof, tx_eof},
            {(idx == 0), (idx == MINB - 1)});
      end else begin
        chk(!tx_sof && !tx_eof, "R6", "markers without valid", {tx_sof, tx_eof}, 0);
      end
      if (idx == 3) begin
        // R9 / R10: these changes must not reach the frame
        station_addr = ~a; pause_dur = ~d; full_duplex = 1'b0;
      end
      if (req_clear) begin
        chk(idx == MINB, "R7", "bytes before clear", idx, MINB);
        chk(gstop_req, "R7", "stop high with clear", gstop_req, 1);
        sw_pause_req = 1'b0;
        done = 1;
      end
      pv = tx_valid; pr = tx_ready; pd = tx_data;
      if (tx_valid && tx_ready) idx++;
    end
    if (!done) chk(1'b0, "R7", "frame never completed", idx, MINB);
    @(negedge clk); #1;
    chk(!gstop_req && !req_clear && !tx_valid, "R7", "stop released after clear",
        {gstop_req, req_clear, tx_valid}, 0);
    full_duplex = 1'b1; data_tx_idle = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "R7", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] durs [5];
    durs[0] = 16'h0000; durs[1] = 16'hFFFF; durs[2] = 16'h1234;
    durs[3] = 16'h00FF; durs[4] = 16'h8001;
    rst_n = 1'b0; sw_pause_req = 1'b0; full_duplex = 1'b0; data_tx_idle = 1'b0;
    tx_ready = 1'b0; station_addr = '0; pause_dur = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!gstop_req && !gstop_done_irq && !req_clear && !tx_valid, "R1",
        "reset state", {gstop_req, gstop_done_irq, req_clear, tx_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: half-duplex request ignored
    sw_pause_req = 1'b1; full_duplex = 1'b0; data_tx_idle = 1'b1; tx_ready = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk); #1;
      chk(!gstop_req && !tx_valid && !req_clear && !gstop_done_irq, "R1",
          "half-duplex request", {gstop_req, tx_valid, req_clear, gstop_done_irq}, 0);
    end
    sw_pause_req = 1'b0;
    @(negedge clk);

    for (int k = 0; k < 5; k++) begin
      for (int m = 0; m < 3; m++) begin
        for (int b = 0; b < 2; b++) begin
          run_frame({8'h02, 8'(k * 17 + m), 8'(k * 3 + 1), 8'hA5, 8'(m * 40 + b), 8'h5A},
                    durs[k], m, b * 4);
        end
      end
    end
    finish_run();
  end
endmodule